// File: doc/BRIEF.md
# SPI Port with Selectable Slave-Select Handling

This block is a byte-wide serial peripheral interface port for a system-clocked chip. Software-facing logic writes a configuration word (enable, master or slave role, a two-bit select-mode code and a clock divider), pushes a transmit byte with a one-cycle write strobe, and reads the received byte from a holding register once the transfer-complete flag is up. As master the port produces SCK itself from the divider. As slave it samples SCK, MOSI and NSS through synchronizers and follows the edges it detects in the system clock domain.

The select-mode code decides what the NSS pin does. Code 00 is three-wire operation: the pin is not used, and a slave is always selected. Code 01 makes NSS an input. A low level selects the port as slave. While the port is master, a falling edge on NSS means another master has taken the bus: the port drops out of master operation and raises a sticky fault flag. With codes 10 and 11 the port drives NSS, and the low bit of the code is the level on the pin. MISO, MOSI, SCK and NSS each have an output-enable so that pads can be tri-stated.

The transmit path has no back-pressure. A write strobe that arrives while a byte is still moving, or while the completion flag has not been cleared, is dropped and reported on a collision flag. This flag takes the place of a ready signal.

Top module: `spi_port`

## Requirements
- R1: Bits travel most-significant first. The master drives MOSI from the MSB of its shift register. A selected slave drives MISO from the MSB of its shift register. The received byte is assembled with the first bit in bit 7.
- R2: As master, SCK idles low and each level lasts div+1 system clocks. Data is sampled on the rising edge and launched on the falling edge. `busy` is high from the edge that accepts the write, and `done_flag` rises exactly 16·(div+1) clocks after that edge, at the same moment `busy` falls.
- R3: After the eighth bit, `rd_byte` holds the received byte and `done_flag` is set. The flag stays set until a `clr_done` pulse.
- R4: A write strobe while the port is enabled and either `busy` or `done_flag` is high sets `coll_flag`. The byte is discarded and no transfer starts. `coll_flag` stays set until `clr_coll`.
- R5: With select-mode 00, `nss_oe` stays low. An enabled slave is always selected and drives MISO (`miso_oe`=1). A master never enables MISO.
- R6: With select-mode 01 and slave role, NSS high deselects the port: `miso_oe` is low and SCK edges are ignored, so they neither shift data nor advance the bit count. NSS low selects the port.
- R7: With select-mode 01 and master role, a high-to-low change on NSS ends master operation. `sck_oe` and `mosi_oe` drop, `busy` clears, no completion is flagged, and `fault_flag` is set. The flag stays set until `clr_fault`, and the port stays out of master operation until the next configuration write.
- R8: With select-mode 10 or 11 and the port enabled, `nss_oe` is 1 and `nss_o` equals bit 0 of the select-mode code.
- R9: While disabled, all four output-enables are low. A write strobe does nothing: it sets no flag and starts no transfer.
- R10: The slave-side pins pass through two synchronizer flops. A change on NSS shows on `miso_oe` after exactly two rising clock edges, and a master sees a mode fault one edge later.
- R11: As master and enabled, `sck_oe` and `mosi_oe` are 1. In every other case they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Loads the configuration fields below and aborts any transfer |
| cfg_en | input | 1 | Port enable |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_mode | input | 2 | Select-mode code (00, 01, 1x) |
| cfg_div | input | DIVW | SCK half-period minus one, in system clocks |
| wr_stb | input | 1 | One-cycle transmit write |
| wr_byte | input | DW | Transmit byte |
| rd_byte | output | DW | Last received byte |
| busy | output | 1 | A byte is in flight |
| done_flag | output | 1 | Sticky transfer-complete flag |
| coll_flag | output | 1 | Sticky write-collision flag |
| fault_flag | output | 1 | Sticky mode-fault flag |
| clr_done | input | 1 | Clears `done_flag` |
| clr_coll | input | 1 | Clears `coll_flag` |
| clr_fault | input | 1 | Clears `fault_flag` |
| sck_o | output | 1 | Generated serial clock |
| sck_oe | output | 1 | SCK pad output-enable |
| sck_i | input | 1 | Serial clock from pad |
| mosi_o | output | 1 | Master-out data |
| mosi_oe | output | 1 | MOSI pad output-enable |
| mosi_i | input | 1 | MOSI from pad (slave role) |
| miso_o | output | 1 | Slave-out data |
| miso_oe | output | 1 | MISO pad output-enable |
| miso_i | input | 1 | MISO from pad (master role) |
| nss_o | output | 1 | Driven select level |
| nss_oe | output | 1 | NSS pad output-enable |
| nss_i | input | 1 | Select from pad |

## Verification
In master role, the bench counts clocks from the edge that accepts a write. It expects SCK to toggle after every div+1 of them and `done_flag` to rise exactly 16·(div+1) edges later. It samples every clock of the transfer on the falling clock edge so that each toggle is seen in its due cycle. Configuration-driven enables respond one edge after `cfg_wr`, and a per-clock model checks them against the written values. Slave inputs are held for four clocks per SCK level, which exceeds the three-edge synchronize-and-detect path. NSS-driven effects are checked at exactly two edges (MISO enable) and three edges (mode fault), with a check one edge earlier confirming they are not early.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam logic [1:0] SEL_3WIRE = 2'b00;
  localparam logic [1:0] SEL_NSS_IN = 2'b01;

  typedef struct packed {
    logic       en;
    logic       master;
    logic [1:0] mode;
  } spi_ctl_t;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int              W      = 3,
  parameter int              STAGES = 2,
  parameter logic [W-1:0]    INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dprev
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES + 1){INIT[i]}};
      else        chain <= {chain[STAGES-1:0], din[i]};
    end
    assign dout[i]  = chain[STAGES-1];
    assign dprev[i] = chain[STAGES];
  end

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            sck_o,
  output logic            rise,
  output logic            fall
);

  logic [DIVW-1:0] cnt;
  logic            hit;

  assign hit  = run && (cnt == div);
  assign rise = hit && !sck_o;
  assign fall = hit && sck_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sck_o <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      sck_o <= 1'b0;
    end else if (hit) begin
      cnt   <= '0;
      sck_o <= !sck_o;
    end else begin
      cnt   <= cnt + DIVW'(1);
    end
  end

  // R2: the clock rests low whenever no transfer runs
  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sck_o);

  // R2: a level is held until the divider count reaches its limit
  p_half_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != div) |=> $stable(sck_o));

endmodule

// File: rtl/spi_shreg.sv
module spi_shreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          samp_en,
  input  logic          samp_bit,
  input  logic          shift_en,
  input  logic          abort,
  output logic          msb,
  output logic [DW-1:0] rx,
  output logic          active,
  output logic          done_o
);

  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] shreg;
  logic          samp;
  logic [CW-1:0] bitcnt;
  logic          last;
  logic [DW-1:0] nxt;

  assign last   = (bitcnt == CW'(DW - 1));
  assign nxt    = {shreg[DW-2:0], samp};
  assign msb    = shreg[DW-1];
  assign active = (bitcnt != '0);
  assign done_o = shift_en && !abort && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      samp   <= 1'b0;
      bitcnt <= '0;
      rx     <= '0;
    end else begin
      if (samp_en) samp <= samp_bit;
      if (abort) begin
        bitcnt <= '0;
      end else if (shift_en) begin
        shreg <= nxt;
        if (last) begin
          bitcnt <= '0;
          rx     <= nxt;
        end else begin
          bitcnt <= bitcnt + CW'(1);
        end
      end
      if (load) shreg <= load_val;
    end
  end

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DIVW   = 8,
  parameter int SYNC_N = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic            cfg_en,
  input  logic            cfg_master,
  input  logic [1:0]      cfg_mode,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            wr_stb,
  input  logic [DW-1:0]   wr_byte,
  output logic [DW-1:0]   rd_byte,
  output logic            busy,
  output logic            done_flag,
  output logic            coll_flag,
  output logic            fault_flag,
  input  logic            clr_done,
  input  logic            clr_coll,
  input  logic            clr_fault,
  output logic            sck_o,
  output logic            sck_oe,
  input  logic            sck_i,
  output logic            mosi_o,
  output logic            mosi_oe,
  input  logic            mosi_i,
  output logic            miso_o,
  output logic            miso_oe,
  input  logic            miso_i,
  output logic            nss_o,
  output logic            nss_oe,
  input  logic            nss_i
);

  localparam int PINS = 3;
  localparam int P_SCK = 2;
  localparam int P_DAT = 1;
  localparam int P_NSS = 0;

  spi_ctl_t        ctl;
  logic [DIVW-1:0] div_q;
  logic            m_run;

  logic [PINS-1:0] pin_s, pin_p;
  logic            sck_s, sck_p, mosi_s, nss_s, nss_p;

  spi_in_sync #(.W(PINS), .STAGES(SYNC_N), .INIT(3'b001)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({sck_i, mosi_i, nss_i}),
    .dout  (pin_s),
    .dprev (pin_p)
  );

  assign sck_s  = pin_s[P_SCK];
  assign sck_p  = pin_p[P_SCK];
  assign mosi_s = pin_s[P_DAT];
  assign nss_s  = pin_s[P_NSS];
  assign nss_p  = pin_p[P_NSS];

  logic slave_act, sel_ok, slv_on, s_rise, s_fall;
  logic fault_hit;
  logic m_rise, m_fall;

  assign slave_act = ctl.en && !ctl.master;
  assign sel_ok    = (ctl.mode == SEL_3WIRE) || ((ctl.mode == SEL_NSS_IN) && !nss_s);
  assign slv_on    = slave_act && sel_ok;
  assign s_rise    = slv_on && sck_s && !sck_p;
  assign s_fall    = slv_on && !sck_s && sck_p;
  assign fault_hit = ctl.en && ctl.master && (ctl.mode == SEL_NSS_IN)
                     && nss_p && !nss_s && !cfg_wr;

  spi_sck_gen #(.DIVW(DIVW)) u_sck (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (m_run),
    .div   (div_q),
    .sck_o (sck_o),
    .rise  (m_rise),
    .fall  (m_fall)
  );

  logic sh_msb, sh_active, sh_done;
  logic accept, collide;

  assign busy    = m_run || sh_active;
  assign accept  = ctl.en && wr_stb && !busy && !done_flag;
  assign collide = ctl.en && wr_stb && (busy || done_flag);

  spi_shreg #(.DW(DW)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (wr_byte),
    .samp_en  (m_rise || s_rise),
    .samp_bit (ctl.master ? miso_i : mosi_s),
    .shift_en (m_fall || s_fall),
    .abort    (fault_hit || cfg_wr),
    .msb      (sh_msb),
    .rx       (rd_byte),
    .active   (sh_active),
    .done_o   (sh_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl   <= '0;
      div_q <= '0;
      m_run <= 1'b0;
    end else if (cfg_wr) begin
      ctl   <= '{en: cfg_en, master: cfg_master, mode: cfg_mode};
      div_q <= cfg_div;
      m_run <= 1'b0;
    end else if (fault_hit) begin
      ctl.master <= 1'b0;
      m_run      <= 1'b0;
    end else if (accept && ctl.master) begin
      m_run <= 1'b1;
    end else if (sh_done) begin
      m_run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag  <= 1'b0;
      coll_flag  <= 1'b0;
      fault_flag <= 1'b0;
    end else begin
      if (sh_done)        done_flag <= 1'b1;
      else if (clr_done)  done_flag <= 1'b0;
      if (collide)        coll_flag <= 1'b1;
      else if (clr_coll)  coll_flag <= 1'b0;
      if (fault_hit)      fault_flag <= 1'b1;
      else if (clr_fault) fault_flag <= 1'b0;
    end
  end

  assign sck_oe  = ctl.en && ctl.master;
  assign mosi_oe = ctl.en && ctl.master;
  assign mosi_o  = sh_msb;
  assign miso_o  = sh_msb;
  assign miso_oe = slv_on;
  assign nss_oe  = ctl.en && ctl.mode[1];
  assign nss_o   = ctl.mode[0];

  // R7: a fault flag that rises always finds master operation already ended
  p_fault_drops_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> !ctl.master);

  // R5: the MISO pad is never driven while acting as master
  p_master_no_miso_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.master |-> !miso_oe);

  // R4: a refused write is flagged and never starts the master clock
  p_coll_discard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.en && wr_stb && done_flag) |=> (coll_flag && !m_run));

endmodule

// File: tb/spi_port_test.sv
`timescale 1ns/1ps
module spi_port_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr, cfg_en, cfg_master;
  logic [1:0] cfg_mode;
  logic [7:0] cfg_div;
  logic       wr_stb;
  logic [7:0] wr_byte, rd_byte;
  logic       busy, done_flag, coll_flag, fault_flag;
  logic       clr_done, clr_coll, clr_fault;
  logic       sck_o, sck_oe, sck_i, mosi_o, mosi_oe, mosi_i;
  logic       miso_o, miso_oe, miso_i, nss_o, nss_oe, nss_i;

  always #2.5 clk = ~clk;

  spi_port uut (.*);

  int n_chk = 0;
  int n_bad = 0;
  logic       mon_en = 1'b0;
  logic       en_s = 1'b0, mst_s = 1'b0;
  logic [1:0] mode_s = 2'b00;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic cfg(input logic e, input logic m, input logic [1:0] md, input logic [7:0] dv);
    cfg_en = e; cfg_master = m; cfg_mode = md; cfg_div = dv; cfg_wr = 1'b1;
    @(posedge clk); #1 en_s = e; mst_s = m; mode_s = md;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic pulse_wr(input logic [7:0] b);
    wr_byte = b; wr_stb = 1'b1; step(1); wr_stb = 1'b0;
  endtask

  task automatic clr_all();
    clr_done = 1'b1; clr_coll = 1'b1; clr_fault = 1'b1; step(1);
    clr_done = 1'b0; clr_coll = 1'b0; clr_fault = 1'b0;
  endtask

  // Per-clock reference for the configuration-driven pad enables (R8, R11)
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      chk("R11 sck_oe model", sck_oe, en_s && mst_s);
      chk("R11 mosi_oe model", mosi_oe, en_s && mst_s);
      chk("R8 nss_oe model", nss_oe, en_s && mode_s[1]);
      if (en_s && mode_s[1]) chk("R8 nss_o model", nss_o, mode_s[0]);
    end
  end

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sl, input int dv, input int coll_at);
    int nn; logic [7:0] sh; logic [7:0] cap; logic sp; logic okb; logic oks;
    nn = 16 * (dv + 1); sh = sl; miso_i = sl[7]; cap = '0; sp = 1'b0; okb = 1'b1; oks = 1'b1;
    pulse_wr(tx);
    if (sck_o !== 1'b0 || busy !== 1'b1) okb = 1'b0;
    for (int n = 1; n <= nn; n++) begin
      if (n == coll_at) begin wr_byte = 8'hFF; wr_stb = 1'b1; end
      step(1); wr_stb = 1'b0;
      if (sck_o && !sp) cap = {cap[6:0], mosi_o};
      if (!sck_o && sp) begin sh = {sh[6:0], 1'b0}; miso_i = sh[7]; end
      sp = sck_o;
      if (n < nn) begin
        if (busy !== 1'b1 || done_flag !== 1'b0) okb = 1'b0;
        if (sck_o !== 1'(((n / (dv + 1)) % 2))) oks = 1'b0;
      end
    end
    chk("R2 busy held, no early done", okb, 1);
    chk("R2 sck idle low and half period", oks, 1);
    chk("R2 done due at 16*(div+1)", done_flag, 1);
    chk("R2 busy ends with done", busy, 0);
    chk("R1 mosi msb first", cap, tx);
    chk("R1 R3 received byte", rd_byte, sl);
  endtask

  task automatic slave_bit(input logic b, output logic m);
    mosi_i = b; sck_i = 1'b0; step(4);
    sck_i = 1'b1; step(4); m = miso_o;
    sck_i = 1'b0; step(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    logic [7:0] got; logic mb;
    rst_n = 1'b0; cfg_wr = 0; cfg_en = 0; cfg_master = 0; cfg_mode = 0; cfg_div = 0;
    wr_stb = 0; wr_byte = 0; clr_done = 0; clr_coll = 0; clr_fault = 0;
    sck_i = 0; mosi_i = 0; miso_i = 0; nss_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1);
    chk("R9 reset done", done_flag, 0);
    chk("R9 reset coll", coll_flag, 0);
    chk("R9 reset fault", fault_flag, 0);
    chk("R9 reset busy", busy, 0);
    chk("R9 reset oes", {sck_oe, mosi_oe, miso_oe, nss_oe}, 0);
    mon_en = 1'b1;

    // master, three-wire, div 1
    cfg(1, 1, 2'b00, 8'd1);
    chk("R5 master miso off", miso_oe, 0);
    chk("R5 nss unused", nss_oe, 0);
    chk("R11 master oes", {sck_oe, mosi_oe}, 2'b11);
    master_xfer(8'hA5, 8'h3C, 1, -1);
    // write while done still set
    pulse_wr(8'h11);
    step(2);
    chk("R4 coll on done", coll_flag, 1);
    chk("R4 no start", busy, 0);
    chk("R3 done sticky", done_flag, 1);
    chk("R4 rx untouched", rd_byte, 8'h3C);
    clr_coll = 1'b1; step(1); clr_coll = 1'b0;
    chk("R4 coll cleared", coll_flag, 0);
    clr_done = 1'b1; step(1); clr_done = 1'b0;
    chk("R3 done cleared", done_flag, 0);

    // slower divider with a collision mid-byte
    cfg(1, 1, 2'b00, 8'd3);
    master_xfer(8'h81, 8'h7E, 3, 5);
    chk("R4 coll while busy", coll_flag, 1);
    clr_all();
    cfg(1, 1, 2'b00, 8'd0);
    master_xfer(8'hC3, 8'h5A, 0, -1);
    clr_all();

    // driven select levels
    cfg(1, 1, 2'b10, 8'd0);
    chk("R8 nss driven low", {nss_oe, nss_o}, 2'b10);
    cfg(1, 1, 2'b11, 8'd0);
    chk("R8 nss driven high", {nss_oe, nss_o}, 2'b11);

    // mode fault in multi-master mode
    cfg(1, 1, 2'b01, 8'd3);
    step(3);
    pulse_wr(8'h55);
    step(10);
    mon_en = 1'b0;
    nss_i = 1'b0;
    step(2);
    chk("R10 fault not before third edge", fault_flag, 0);
    step(1);
    chk("R7 fault raised", fault_flag, 1);
    chk("R7 master dropped", {sck_oe, mosi_oe}, 2'b00);
    chk("R7 transfer aborted", busy, 0);
    mst_s = 1'b0; mon_en = 1'b1;
    step(40);
    chk("R7 fault sticky", fault_flag, 1);
    chk("R7 no completion", done_flag, 0);
    clr_fault = 1'b1; step(1); clr_fault = 1'b0;
    chk("R7 fault cleared", fault_flag, 0);
    chk("R7 stays slave", sck_oe, 0);
    nss_i = 1'b1; step(3);

    // disabled port
    cfg(0, 0, 2'b00, 8'd0);
    chk("R9 disabled oes", {sck_oe, mosi_oe, miso_oe, nss_oe}, 0);
    pulse_wr(8'h99); step(3);
    chk("R9 write ignored", {busy, done_flag, coll_flag}, 0);

    // three-wire slave
    cfg(1, 0, 2'b00, 8'd0);
    chk("R5 slave always selected", miso_oe, 1);
    pulse_wr(8'h96);
    chk("R1 slave miso msb", miso_o, 1);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      slave_bit(1'(8'hD2 >> (7 - i)), mb);
      got = {got[6:0], mb};
    end
    chk("R1 slave miso stream", got, 8'h96);
    chk("R3 slave rx byte", rd_byte, 8'hD2);
    chk("R3 slave done", done_flag, 1);
    clr_all();

    // four-wire slave with deselected edges
    cfg(1, 0, 2'b01, 8'd0);
    step(1);
    chk("R6 deselected miso off", miso_oe, 0);
    pulse_wr(8'h3C);
    for (int i = 0; i < 3; i++) slave_bit(1'b1, mb);
    nss_i = 1'b0; step(1);
    chk("R10 miso_oe not after one edge", miso_oe, 0);
    step(1);
    chk("R10 R6 miso_oe after two edges", miso_oe, 1);
    got = '0;
    for (int i = 0; i < 7; i++) begin
      slave_bit(1'(8'hA7 >> (7 - i)), mb);
      got = {got[6:0], mb};
    end
    chk("R6 ignored edges not counted", done_flag, 0);
    slave_bit(1'b1, mb);
    got = {got[6:0], mb};
    chk("R6 slave done after 8 bits", done_flag, 1);
    chk("R6 slave rx byte", rd_byte, 8'hA7);
    chk("R6 shift untouched while deselected", got, 8'h3C);
    nss_i = 1'b1; step(2);
    chk("R6 deselect hiz", miso_oe, 0);

    finish_up();
  end

endmodule